// File: doc/BRIEF.md
# Command ring fetch engine

This block is the instruction-fetch front end of a 2D drawing accelerator. Software fills a circular buffer in memory with 32-bit instruction words and moves a tail pointer forward. The engine keeps its own execution head. While it is running, it reads the word at the head, offers it to the downstream execution unit on a valid/ready stream, and moves the head by one word once that word is taken. When the head reaches the end of the ring (base plus length), it goes back to the base.

Software drives the block through a small register port: a control word with stop and abort bits, the ring geometry, the tail, a read-only view of the execution head, and an interrupt status/enable pair. An end-of-execution status bit is set when the head catches up with the tail. Three error inputs from the execution unit set their own status bits. The interrupt line is raised whenever an enabled status bit is set. Memory is reached through a single-word read request with a separate response strobe, and the engine never has more than one read outstanding.

Top module: `cmd_ring_fetch`

## Requirements
- R1: Registers sit at these byte offsets: control 0x00, status 0x04, ring base 0x08, ring length 0x0C, tail 0x10, execution head 0x14 (read-only), interrupt enable 0x18. Other offsets read 0. After reset:
  - control reads 0x10 (stop set);
  - base, length, tail and head read 0;
  - status and enable read 0;
  - irq, mem_req_valid and ins_valid are low.
- R2: A write to the ring base clears its low 8 bits. Writes to the tail and the length clear their low 2 bits.
- R3: While running, the engine reads words in order from the address held in the head and presents each on the instruction stream. The head moves forward by 4 only when a word is accepted. No read is issued while the head equals the tail.
- R4: If head plus 4 equals base plus length when a word is accepted, the head returns to the base.
- R5: While control bit 4 (stop) is set, no new read begins. When stop is clear and the engine is idle, a tail write places a read request on the port in the second cycle after the write edge.
- R6: While the ring length is 0, no read begins, even when stop is clear and the tail differs from the head.
- R7: Writing 1 to control bit 6 (abort) does the following:
  - it discards any held word;
  - it sets stop;
  - it moves the head to the tail;
  - it drops the response of any read still in flight, which is never presented.
  The abort bit itself always reads 0.
- R8: At most one memory read is outstanding. Unless an abort or a base write intervenes, a request stays valid with a stable address until it is accepted, and an offered word stays valid and stable until it is accepted.
- R9: Status bit 5 (end of execution) is set when an accepted word makes the head equal to the tail.
- R10: A pulse on each error input sets its status bit: bad instruction sets bit 1, bad operation sets bit 3, bad pixel format sets bit 4.
- R11: Writing 1 to a status bit clears it. If an event sets the same bit in the same cycle, the set wins.
- R12: Only bits 1, 3, 4 and 5 of the enable register are writable. irq is high exactly when some status bit and the same enable bit are both set.
- R13: A write to the ring base also loads the execution head with the new aligned base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req_valid | output | 1 | Word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | DATA_W | Read data |
| ins_valid | output | 1 | Instruction word offered |
| ins_ready | input | 1 | Execution unit takes the word |
| ins_data | output | DATA_W | Instruction word |
| err_bad_ins | input | 1 | Execution unit saw an illegal instruction |
| err_bad_op | input | 1 | Execution unit saw an illegal operation |
| err_bad_fmt | input | 1 | Execution unit saw an illegal pixel format |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker checks these on every cycle:
- a single outstanding read;
- requests and offered words stay stable under back-pressure;
- no read starts while stop was set or while the head equalled the tail;
- the head stays word-aligned;
- end-of-execution only rises after an accepted word;
- irq stays low when status is empty.

The ordering of fetched words, wrap-around at base plus length, and the effect of stop and of a zero length can only be shown by the bench scenarios. The same holds for abort discarding both a held word and an in-flight response, address masking, and write-one-to-clear with set priority. The bench sweeps request back-pressure, response latency, stream back-pressure and burst length against an arithmetic model of the ring.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;

    localparam int REG_AW     = 8;
    localparam int REG_DW     = 32;
    localparam int WORD_BYTES = 4;

    localparam logic [REG_AW-1:0] OFS_CTRL = 8'h00;
    localparam logic [REG_AW-1:0] OFS_STAT = 8'h04;
    localparam logic [REG_AW-1:0] OFS_BASE = 8'h08;
    localparam logic [REG_AW-1:0] OFS_LEN  = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_TAIL = 8'h10;
    localparam logic [REG_AW-1:0] OFS_HEAD = 8'h14;
    localparam logic [REG_AW-1:0] OFS_IEN  = 8'h18;

    localparam int BIT_STOP  = 4;
    localparam int BIT_ABORT = 6;

    localparam int STAT_W     = 6;
    localparam int ST_BAD_INS = 1;
    localparam int ST_BAD_OP  = 3;
    localparam int ST_BAD_FMT = 4;
    localparam int ST_EOE     = 5;
    localparam logic [STAT_W-1:0] STAT_MASK = 6'b111010;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_REQ,
        FS_WAIT,
        FS_HOLD,
        FS_DRAIN
    } fetch_state_e;

endpackage

// File: rtl/ring_ctrl_regs.sv
module ring_ctrl_regs
    import cmd_ring_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BASE_ALIGN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic [ADDR_W-1:0] head,
    input  logic [STAT_W-1:0] stat,
    input  logic [STAT_W-1:0] ien,
    output logic              stop,
    output logic              abort,
    output logic              base_load,
    output logic [ADDR_W-1:0] base_val,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] len,
    output logic [ADDR_W-1:0] tail
);

    localparam logic [ADDR_W-1:0] BASE_MASK = ~((ADDR_W'(1) << BASE_ALIGN) - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(WORD_BYTES - 1);

    typedef struct packed {
        logic              stop;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] len;
        logic [ADDR_W-1:0] tail;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_ctrl, wr_base, wr_len, wr_tail;

    always_comb begin
        wr_ctrl  = reg_we && (reg_addr == OFS_CTRL);
        wr_base  = reg_we && (reg_addr == OFS_BASE);
        wr_len   = reg_we && (reg_addr == OFS_LEN);
        wr_tail  = reg_we && (reg_addr == OFS_TAIL);
        abort    = wr_ctrl && reg_wdata[BIT_ABORT];
        base_val = reg_wdata[ADDR_W-1:0] & BASE_MASK;
        base_load = wr_base;

        r_d = r_q;
        if (wr_ctrl) r_d.stop = reg_wdata[BIT_STOP] | reg_wdata[BIT_ABORT];
        if (wr_base) r_d.base = base_val;
        if (wr_len)  r_d.len  = reg_wdata[ADDR_W-1:0] & WORD_MASK;
        if (wr_tail) r_d.tail = reg_wdata[ADDR_W-1:0] & WORD_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.stop <= 1'b1;
            r_q.base <= '0;
            r_q.len  <= '0;
            r_q.tail <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CTRL: reg_rdata[BIT_STOP] = r_q.stop;
            OFS_STAT: reg_rdata = REG_DW'(stat);
            OFS_BASE: reg_rdata = REG_DW'(r_q.base);
            OFS_LEN:  reg_rdata = REG_DW'(r_q.len);
            OFS_TAIL: reg_rdata = REG_DW'(r_q.tail);
            OFS_HEAD: reg_rdata = REG_DW'(head);
            OFS_IEN:  reg_rdata = REG_DW'(ien);
            default:  reg_rdata = '0;
        endcase
    end

    assign stop = r_q.stop;
    assign base = r_q.base;
    assign len  = r_q.len;
    assign tail = r_q.tail;

endmodule

// File: rtl/ring_fetch_engine.sv
module ring_fetch_engine
    import cmd_ring_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop,
    input  logic              abort,
    input  logic              base_load,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] len,
    input  logic [ADDR_W-1:0] tail,
    output logic [ADDR_W-1:0] head,
    output logic              eoe_pulse,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              ins_valid,
    input  logic              ins_ready,
    output logic [DATA_W-1:0] ins_data
);

    typedef struct packed {
        fetch_state_e      st;
        logic [ADDR_W-1:0] head;
        logic [DATA_W-1:0] word;
    } fetch_t;

    fetch_t            f_d, f_q;
    logic [ADDR_W-1:0] head_inc, ring_end, head_adv;
    logic              can_start;

    always_comb begin
        f_d       = f_q;
        eoe_pulse = 1'b0;
        head_inc  = f_q.head + ADDR_W'(WORD_BYTES);
        ring_end  = base + len;
        head_adv  = (head_inc == ring_end) ? base : head_inc;
        can_start = !stop && (len != '0) && (f_q.head != tail);

        unique case (f_q.st)
            FS_IDLE:  if (can_start) f_d.st = FS_REQ;
            FS_REQ:   if (mem_req_ready) f_d.st = FS_WAIT;
            FS_WAIT: begin
                if (mem_rsp_valid) begin
                    f_d.st   = FS_HOLD;
                    f_d.word = mem_rsp_data;
                end
            end
            FS_HOLD: begin
                if (ins_ready) begin
                    f_d.st    = FS_IDLE;
                    f_d.head  = head_adv;
                    eoe_pulse = (head_adv == tail);
                end
            end
            FS_DRAIN: if (mem_rsp_valid) f_d.st = FS_IDLE;
            default:  f_d.st = FS_IDLE;
        endcase

        if (abort) begin
            f_d.head  = tail;
            eoe_pulse = 1'b0;
            unique case (f_q.st)
                FS_REQ:   f_d.st = mem_req_ready ? FS_DRAIN : FS_IDLE;
                FS_WAIT:  f_d.st = mem_rsp_valid ? FS_IDLE : FS_DRAIN;
                FS_DRAIN: f_d.st = mem_rsp_valid ? FS_IDLE : FS_DRAIN;
                default:  f_d.st = FS_IDLE;
            endcase
        end else if (base_load) begin
            f_d.head = base_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.st   <= FS_IDLE;
            f_q.head <= '0;
            f_q.word <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign head          = f_q.head;
    assign mem_req_valid = (f_q.st == FS_REQ);
    assign mem_req_addr  = f_q.head;
    assign ins_valid     = (f_q.st == FS_HOLD);
    assign ins_data      = f_q.word;

endmodule

// File: rtl/ring_irq_ctrl.sv
module ring_irq_ctrl
    import cmd_ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stat,
    input  logic              wr_ien,
    input  logic [STAT_W-1:0] wdata,
    input  logic              ev_bad_ins,
    input  logic              ev_bad_op,
    input  logic              ev_bad_fmt,
    input  logic              ev_eoe,
    output logic [STAT_W-1:0] stat,
    output logic [STAT_W-1:0] ien,
    output logic              irq
);

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [STAT_W-1:0] ien;
    } irq_t;

    irq_t              i_d, i_q;
    logic [STAT_W-1:0] set_vec, clr_vec, stat_next;

    always_comb begin
        set_vec             = '0;
        set_vec[ST_BAD_INS] = ev_bad_ins;
        set_vec[ST_BAD_OP]  = ev_bad_op;
        set_vec[ST_BAD_FMT] = ev_bad_fmt;
        set_vec[ST_EOE]     = ev_eoe;
        clr_vec             = wr_stat ? wdata : '0;
    end

    for (genvar b = 0; b < STAT_W; b++) begin : g_stat_bit
        if (STAT_MASK[b]) begin : g_live
            assign stat_next[b] = (i_q.stat[b] & ~clr_vec[b]) | set_vec[b];
        end else begin : g_tied
            assign stat_next[b] = 1'b0;
        end
    end

    always_comb begin
        i_d      = i_q;
        i_d.stat = stat_next;
        if (wr_ien) i_d.ien = wdata & STAT_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_q <= '0;
        end else begin
            i_q <= i_d;
        end
    end

    assign stat = i_q.stat;
    assign ien  = i_q.ien;
    assign irq  = |(i_q.stat & i_q.ien);

endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
    import cmd_ring_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int BASE_ALIGN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              ins_valid,
    input  logic              ins_ready,
    output logic [DATA_W-1:0] ins_data,
    input  logic              err_bad_ins,
    input  logic              err_bad_op,
    input  logic              err_bad_fmt,
    output logic              irq
);

    logic              ring_stop, ring_abort, ring_base_load;
    logic [ADDR_W-1:0] ring_base_val, ring_base, ring_len, ring_tail, exec_head;
    logic [STAT_W-1:0] irq_stat, irq_en;
    logic              eoe_pulse, wr_stat, wr_ien;

    assign wr_stat = reg_we && (reg_addr == OFS_STAT);
    assign wr_ien  = reg_we && (reg_addr == OFS_IEN);

    ring_ctrl_regs #(
        .ADDR_W     (ADDR_W),
        .BASE_ALIGN (BASE_ALIGN)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .head      (exec_head),
        .stat      (irq_stat),
        .ien       (irq_en),
        .stop      (ring_stop),
        .abort     (ring_abort),
        .base_load (ring_base_load),
        .base_val  (ring_base_val),
        .base      (ring_base),
        .len       (ring_len),
        .tail      (ring_tail)
    );

    ring_fetch_engine #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .stop          (ring_stop),
        .abort         (ring_abort),
        .base_load     (ring_base_load),
        .base_val      (ring_base_val),
        .base          (ring_base),
        .len           (ring_len),
        .tail          (ring_tail),
        .head          (exec_head),
        .eoe_pulse     (eoe_pulse),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .ins_valid     (ins_valid),
        .ins_ready     (ins_ready),
        .ins_data      (ins_data)
    );

    ring_irq_ctrl u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stat    (wr_stat),
        .wr_ien     (wr_ien),
        .wdata      (reg_wdata[STAT_W-1:0]),
        .ev_bad_ins (err_bad_ins),
        .ev_bad_op  (err_bad_op),
        .ev_bad_fmt (err_bad_fmt),
        .ev_eoe     (eoe_pulse),
        .stat       (irq_stat),
        .ien        (irq_en),
        .irq        (irq)
    );

endmodule

// File: rtl/ring_fetch_checker.sv
module ring_fetch_checker
    import cmd_ring_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [REG_DW-1:0] reg_wdata,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              ins_valid,
    input logic              ins_ready,
    input logic [DATA_W-1:0] ins_data,
    input logic              irq,
    input logic [ADDR_W-1:0] head,
    input logic [ADDR_W-1:0] tail,
    input logic              stop,
    input logic [STAT_W-1:0] stat
);

    logic in_flight_q;
    logic abort_wr, base_wr;

    assign abort_wr = reg_we && (reg_addr == OFS_CTRL) && reg_wdata[BIT_ABORT];
    assign base_wr  = reg_we && (reg_addr == OFS_BASE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_flight_q <= 1'b0;
        end else if (mem_req_valid && mem_req_ready) begin
            in_flight_q <= 1'b1;
        end else if (mem_rsp_valid) begin
            in_flight_q <= 1'b0;
        end
    end

    // R8: no second request while a response is pending
    p_single_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !in_flight_q);

    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready && !abort_wr && !base_wr)
        |=> (mem_req_valid && $stable(mem_req_addr)));

    p_ins_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_ready && !abort_wr) |=> (ins_valid && $stable(ins_data)));

    p_stop_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(!stop));

    p_not_past_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(head != tail));

    p_head_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        head[1:0] == 2'b00);

    p_eoe_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[ST_EOE]) |-> $past(ins_valid && ins_ready));

    p_irq_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (stat == '0) |-> !irq);

endmodule

bind cmd_ring_fetch ring_fetch_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .ins_valid     (ins_valid),
    .ins_ready     (ins_ready),
    .ins_data      (ins_data),
    .irq           (irq),
    .head          (exec_head),
    .tail          (ring_tail),
    .stop          (ring_stop),
    .stat          (irq_stat)
);

// File: tb/cmd_ring_fetch_tb.sv
`timescale 1ns/1ps
module cmd_ring_fetch_tb;

    localparam int AW = 16;
    localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_BASE = 8'h08,
                           A_LEN = 8'h0C, A_TAIL = 8'h10, A_HEAD = 8'h14, A_IEN = 8'h18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [31:0]   mem_rsp_data = '0;
    logic          ins_valid;
    logic          ins_ready = 1'b0;
    logic [31:0]   ins_data;
    logic          err_bad_ins = 1'b0, err_bad_op = 1'b0, err_bad_fmt = 1'b0;
    logic          irq;

    always #4 clk = ~clk;

    cmd_ring_fetch #(.ADDR_W(AW), .DATA_W(32), .BASE_ALIGN(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_data(ins_data), .err_bad_ins(err_bad_ins), .err_bad_op(err_bad_op),
        .err_bad_fmt(err_bad_fmt), .irq(irq)
    );

    int nchk = 0, nerr = 0;
    int cyc = 0;
    int rmode = 0, imode = 0, lat = 0;
    bit pend = 0;
    int dly = 0;
    logic [AW-1:0] paddr = '0;
    logic [31:0] got [0:63];
    int ngot = 0;
    int bse = 0, ln = 0, cur = 0;
    bit done = 0;

    function automatic logic [31:0] fword(input logic [AW-1:0] a);
        return {a ^ 16'h5A5A, a};
    endfunction

    function automatic int adv(input int c, input int nw);
        return bse + ((c - bse + 4 * nw) % ln);
    endfunction

    // memory and stream models, all on the falling edge
    always @(negedge clk) begin
        cyc++;
        mem_rsp_valid = 1'b0;
        if (pend) begin
            if (dly == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = fword(paddr);
                pend = 0;
            end else begin
                dly--;
            end
        end
        case (rmode)
            0: mem_req_ready = 1'b1;
            1: mem_req_ready = (cyc % 2) == 0;
            default: mem_req_ready = (cyc % 3) == 2;
        endcase
        if (mem_req_valid && mem_req_ready) begin
            pend = 1; dly = lat; paddr = mem_req_addr;
        end
        case (imode)
            0: ins_ready = 1'b1;
            1: ins_ready = (cyc % 2) == 1;
            2: ins_ready = (cyc % 3) != 0;
            default: ins_ready = 1'b0;
        endcase
        if (ins_valid && ins_ready) begin
            if (ngot < 64) got[ngot] = ins_data;
            ngot++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic drain(input string req);
        logic [31:0] h, t;
        bit ok = 0;
        for (int k = 0; k < 600; k++) begin
            rd(A_HEAD, h); rd(A_TAIL, t);
            if (h == t && !ins_valid && !pend && !mem_req_valid) begin ok = 1; break; end
        end
        if (!ok) chk(req, 32'd0, 32'd1);
        repeat (3) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_words(input string req, input int start, input int n);
        chk(req, 32'(ngot), 32'(n));
        for (int i = 0; i < n && i < 64; i++)
            chk(req, got[i], fword(AW'(adv(start, i))));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        int start;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h10);
        rd(A_STAT, v); chk("R1 stat", v, 0);
        rd(A_BASE, v); chk("R1 base", v, 0);
        rd(A_LEN, v);  chk("R1 len", v, 0);
        rd(A_TAIL, v); chk("R1 tail", v, 0);
        rd(A_HEAD, v); chk("R1 head", v, 0);
        rd(A_IEN, v);  chk("R1 ien", v, 0);
        rd(8'h1C, v);  chk("R1 unmapped", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 req", {31'd0, mem_req_valid}, 0);
        chk("R1 ins", {31'd0, ins_valid}, 0);

        // R3 R9 basic fetch
        bse = 32'h100; ln = 32'h40; cur = bse;
        wr(A_LEN, 0); wr(A_BASE, 32'(bse)); wr(A_TAIL, 32'(adv(cur, 4))); wr(A_LEN, 32'(ln));
        ngot = 0;
        wr(A_CTRL, 0);
        drain("R3 drain");
        chk_words("R3 basic", cur, 4);
        cur = adv(cur, 4);
        rd(A_HEAD, v); chk("R3 head", v, 32'(cur));
        rd(A_STAT, v); chk("R9 eoe", v, 32'h20);
        chk("R12 irq masked", {31'd0, irq}, 0);
        wr(A_IEN, 32'hFF);
        rd(A_IEN, v); chk("R12 ien mask", v, 32'h3A);
        chk("R12 irq on", {31'd0, irq}, 1);
        wr(A_STAT, 32'h20);
        rd(A_STAT, v); chk("R11 w1c", v, 0);
        chk("R12 irq off", {31'd0, irq}, 0);
        wr(A_IEN, 0);

        // R4 wrap
        ngot = 0; start = cur;
        wr(A_TAIL, 32'(adv(cur, 14)));
        drain("R4 drain");
        chk_words("R4 wrap", start, 14);
        cur = adv(cur, 14);
        rd(A_HEAD, v); chk("R4 head", v, 32'(cur));
        chk("R4 head wrapped", v, 32'h108);

        // R3 R8 sweep over back-pressure, latency and burst length
        for (int rm = 0; rm < 3; rm++)
            for (int im = 0; im < 3; im++)
                for (int lt = 0; lt < 3; lt++)
                    for (int n = 1; n <= 5; n++) begin
                        rmode = rm; imode = im; lat = lt;
                        ngot = 0; start = cur;
                        wr(A_TAIL, 32'(adv(cur, n)));
                        drain("R3 sweep drain");
                        chk_words("R3 sweep", start, n);
                        cur = adv(cur, n);
                        rd(A_HEAD, v); chk("R3 sweep head", v, 32'(cur));
                    end
        rmode = 0; imode = 0; lat = 0;

        // R5 stop blocks fetch
        wr(A_CTRL, 32'h10);
        ngot = 0; start = cur;
        wr(A_TAIL, 32'(adv(cur, 3)));
        idle(20);
        chk("R5 stopped count", 32'(ngot), 0);
        rd(A_HEAD, v); chk("R5 stopped head", v, 32'(cur));
        wr(A_CTRL, 0);
        drain("R5 drain");
        chk_words("R5 resumed", start, 3);
        cur = adv(cur, 3);

        // R5 request appears in the second cycle after the tail write edge
        wr(A_TAIL, 32'(adv(cur, 1)));
        #1 chk("R5 not yet", {31'd0, mem_req_valid}, 0);
        @(negedge clk);
        #1 chk("R5 next cycle", {31'd0, mem_req_valid}, 1);
        ngot = 0;
        drain("R5 drain2");
        cur = adv(cur, 1);

        // R6 zero length disables
        wr(A_LEN, 0);
        ngot = 0; start = cur;
        wr(A_TAIL, 32'(adv(cur, 2)));
        idle(20);
        chk("R6 no fetch", 32'(ngot), 0);
        rd(A_HEAD, v); chk("R6 head", v, 32'(cur));
        wr(A_LEN, 32'(ln));
        drain("R6 drain");
        chk_words("R6 enabled", start, 2);
        cur = adv(cur, 2);

        // R2 R13 alignment and head reload
        wr(A_CTRL, 32'h10);
        wr(A_BASE, 32'h2F3);
        rd(A_BASE, v); chk("R2 base align", v, 32'h200);
        rd(A_HEAD, v); chk("R13 head reload", v, 32'h200);
        wr(A_TAIL, 32'h20B);
        rd(A_TAIL, v); chk("R2 tail align", v, 32'h208);
        wr(A_LEN, 32'h43);
        rd(A_LEN, v); chk("R2 len align", v, 32'h40);
        bse = 32'h200; cur = bse; ngot = 0;
        wr(A_CTRL, 0);
        drain("R13 drain");
        chk_words("R13 from new base", cur, 2);
        cur = adv(cur, 2);

        // R7 abort while a word is held
        imode = 3; ngot = 0;
        wr(A_TAIL, 32'(adv(cur, 3)));
        idle(15);
        chk("R8 held", {31'd0, ins_valid}, 1);
        wr(A_CTRL, 32'h40);
        #1 chk("R7 drop held", {31'd0, ins_valid}, 0);
        rd(A_CTRL, v); chk("R7 stop set", v, 32'h10);
        cur = adv(cur, 3);
        rd(A_HEAD, v); chk("R7 head to tail", v, 32'(cur));
        imode = 0;
        idle(20);
        chk("R7 nothing after", 32'(ngot), 0);

        // R7 abort with a read in flight
        lat = 8; ngot = 0;
        wr(A_CTRL, 0);
        wr(A_TAIL, 32'(adv(cur, 2)));
        wr(A_CTRL, 32'h40);
        idle(25);
        chk("R7 stale dropped", 32'(ngot), 0);
        cur = adv(cur, 2);
        rd(A_HEAD, v); chk("R7 head", v, 32'(cur));
        lat = 0;
        wr(A_CTRL, 0);
        start = cur;
        wr(A_TAIL, 32'(adv(cur, 1)));
        drain("R7 drain");
        chk_words("R7 fresh word", start, 1);
        cur = adv(cur, 1);

        // R10 R11 R12 error flags
        wr(A_STAT, 32'hFF);
        rd(A_STAT, v); chk("R11 clear all", v, 0);
        @(negedge clk); err_bad_ins = 1'b1;
        @(negedge clk); err_bad_ins = 1'b0;
        rd(A_STAT, v); chk("R10 bad ins", v, 32'h02);
        @(negedge clk); err_bad_op = 1'b1; err_bad_fmt = 1'b1;
        @(negedge clk); err_bad_op = 1'b0; err_bad_fmt = 1'b0;
        rd(A_STAT, v); chk("R10 op fmt", v, 32'h1A);
        chk("R12 no enable", {31'd0, irq}, 0);
        wr(A_IEN, 32'h08);
        chk("R12 op enabled", {31'd0, irq}, 1);
        wr(A_STAT, 32'h08);
        rd(A_STAT, v); chk("R11 selective", v, 32'h12);
        chk("R12 after clear", {31'd0, irq}, 0);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h08; err_bad_op = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; err_bad_op = 1'b0;
        rd(A_STAT, v); chk("R11 set wins", v, 32'h1A);
        chk("R12 irq again", {31'd0, irq}, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule